// File: doc/BRIEF.md
# Virtual processor run/halt controller

This block starts and stops a set of virtual processors (VPs) on behalf of software and reports which of them are running. Software uses a small register bus with an address, a write strobe, 64-bit write data and combinational 64-bit read data. A write to the run register asks every selected idle VP to take a core reset and leave halt. A write to the stop register halts every selected VP that is running. The status register returns one running bit per VP.

Each VP has its own one-cycle reset request, one-cycle halt request and a reset-complete acknowledge input. A VP counts as running only once its acknowledge has come back. The three registers can be reached through two address windows that behave the same. When the controller leaves reset it starts the VPs named by a start-mask parameter, with no help from software. A start mask with a bit at or above the VP count stops elaboration with an error.

Register layout inside each window: run at byte offset 0x00, stop at 0x08, status at 0x10. The windows start at `WIN_A_BASE` (default 0x000) and `WIN_B_BASE` (default 0x100).

Top module: `vp_run_ctrl`

## Requirements
- R1: Before a run or stop write is used, its data is ANDed with a mask of NUM_VP low ones. Data bits at or above NUM_VP produce no request and change no running bit.
- R2: A write to the run register pulses `vp_reset_req[i]` in the cycle after the write. This happens only for each selected VP i whose running bit is clear and which has no reset pending.
- R3: While a VP's reset is pending (its request has been sent and its acknowledge has not arrived), a further run write does not send it another reset request.
- R4: A VP's running bit is set only on a clock edge where `vp_reset_done[i]` is high while that VP's reset is pending. An acknowledge with no reset pending changes nothing.
- R5: A write to the stop register pulses `vp_halt_req[i]` in the cycle after the write, for each selected VP that is running. At the same edge it clears their running bits. A selected VP that is not running gets no halt request.
- R6: A read of the status register returns the running bits in bits NUM_VP-1:0 and zero above them.
- R7: The run, stop and status registers act the same at window A and window B offsets.
- R8: Once reset is released, all running bits read as zero. The first clock edge after release issues a run request for START_RUNNING, so those VPs pulse `vp_reset_req` in the first cycle after that edge.
- R9: A write to any other address leaves every request and running bit unchanged. A read of any other address returns zero, and this includes the run and stop offsets.
- R10: Each reset or halt request pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr`, combinational |
| vp_reset_req | output | NUM_VP | One-cycle core reset and release request, per VP |
| vp_halt_req | output | NUM_VP | One-cycle halt request, per VP |
| vp_reset_done | input | NUM_VP | Reset-complete acknowledge, per VP |

## Verification
The assertions assume that each core raises `vp_reset_done` only after it has seen its reset request. They do not treat a stray acknowledge as an error, and they only check that it cannot set a running bit. They also assume the bus keeps `bus_wr` low during reset. The bench releases reset with the bus idle and acknowledges pending VPs some cycles after their requests. On purpose it also drives a few acknowledges for VPs with no reset pending, and writes that select pending, running or nonexistent VPs, so that the filtering rules get exercised.

// File: rtl/vp_run_ctrl_pkg.sv
package vp_run_ctrl_pkg;

    localparam int DATA_W = 64;

    localparam logic [7:0] OFS_RUN  = 8'h00;
    localparam logic [7:0] OFS_STOP = 8'h08;
    localparam logic [7:0] OFS_STAT = 8'h10;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_RUN,
        SEL_STOP,
        SEL_STAT
    } reg_sel_e;

    typedef struct packed {
        logic running;
        logic pending;
        logic reset_req;
        logic halt_req;
    } vp_state_t;

    typedef struct packed {
        logic boot;
    } ctl_state_t;

endpackage

// File: rtl/vp_run_ctrl_decode.sv
module vp_run_ctrl_decode
    import vp_run_ctrl_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter logic [11:0] WIN_A_BASE = 12'h000,
    parameter logic [11:0] WIN_B_BASE = 12'h100
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam int NUM_WIN = 2;

    logic [NUM_WIN-1:0][ADDR_W-1:0] win_base;
    assign win_base[0] = ADDR_W'(WIN_A_BASE);
    assign win_base[1] = ADDR_W'(WIN_B_BASE);

    always_comb begin
        sel = SEL_NONE;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (addr == win_base[w] + ADDR_W'(OFS_RUN))  sel = SEL_RUN;
            if (addr == win_base[w] + ADDR_W'(OFS_STOP)) sel = SEL_STOP;
            if (addr == win_base[w] + ADDR_W'(OFS_STAT)) sel = SEL_STAT;
        end
    end

endmodule

// File: rtl/vp_run_ctrl_slice.sv
module vp_run_ctrl_slice
    import vp_run_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_sel,
    input  logic stop_sel,
    input  logic reset_done,
    output logic running,
    output logic pending,
    output logic reset_req,
    output logic halt_req
);

    vp_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.reset_req = run_sel && !st_q.running && !st_q.pending;
        st_d.halt_req  = stop_sel && st_q.running;
        if (st_d.reset_req) begin
            st_d.pending = 1'b1;
        end
        if (st_q.pending && reset_done) begin
            st_d.pending = 1'b0;
            st_d.running = 1'b1;
        end
        if (st_d.halt_req) begin
            st_d.running = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign running   = st_q.running;
    assign pending   = st_q.pending;
    assign reset_req = st_q.reset_req;
    assign halt_req  = st_q.halt_req;

endmodule

// File: rtl/vp_run_ctrl.sv
module vp_run_ctrl
    import vp_run_ctrl_pkg::*;
#(
    parameter int          NUM_VP        = 1,
    parameter logic [63:0] START_RUNNING = 64'h1,
    parameter int          ADDR_W        = 12,
    parameter logic [11:0] WIN_A_BASE    = 12'h000,
    parameter logic [11:0] WIN_B_BASE    = 12'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    output logic [NUM_VP-1:0] vp_reset_req,
    output logic [NUM_VP-1:0] vp_halt_req,
    input  logic [NUM_VP-1:0] vp_reset_done
);

    localparam logic [DATA_W-1:0] VALID_MASK = {DATA_W{1'b1}} >> (DATA_W - NUM_VP);
    localparam logic [DATA_W-1:0] BOOT_MASK  = START_RUNNING & VALID_MASK;

    if (NUM_VP < 1 || NUM_VP > DATA_W) begin : g_bad_count
        $error("vp_run_ctrl: NUM_VP must lie in 1..64");
    end
    if (START_RUNNING > VALID_MASK) begin : g_bad_start
        $error("vp_run_ctrl: START_RUNNING names a VP beyond NUM_VP");
    end

    reg_sel_e sel;

    vp_run_ctrl_decode #(
        .ADDR_W    (ADDR_W),
        .WIN_A_BASE(WIN_A_BASE),
        .WIN_B_BASE(WIN_B_BASE)
    ) u_decode (
        .addr(bus_addr),
        .sel (sel)
    );

    ctl_state_t ctl_d, ctl_q;
    logic [DATA_W-1:0] wdata_masked;
    logic [DATA_W-1:0] run_vec;
    logic [DATA_W-1:0] stop_vec;
    logic              wdata_unused;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.boot   = 1'b0;
        wdata_masked = bus_wdata & VALID_MASK;
        run_vec      = '0;
        stop_vec     = '0;
        if (bus_wr && sel == SEL_RUN)  run_vec  = wdata_masked;
        if (bus_wr && sel == SEL_STOP) stop_vec = wdata_masked;
        if (ctl_q.boot)                run_vec  = run_vec | BOOT_MASK;
    end

    assign wdata_unused = ^{run_vec, stop_vec};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{boot: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    logic [NUM_VP-1:0] running_vec;
    logic [NUM_VP-1:0] pending_vec;

    for (genvar i = 0; i < NUM_VP; i++) begin : g_vp
        vp_run_ctrl_slice u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_sel   (run_vec[i]),
            .stop_sel  (stop_vec[i]),
            .reset_done(vp_reset_done[i]),
            .running   (running_vec[i]),
            .pending   (pending_vec[i]),
            .reset_req (vp_reset_req[i]),
            .halt_req  (vp_halt_req[i])
        );
    end

    assign bus_rdata = (sel == SEL_STAT) ? DATA_W'(running_vec) : '0;

endmodule

// File: rtl/vp_run_ctrl_chk.sv
module vp_run_ctrl_chk #(
    parameter int NUM_VP = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_VP-1:0] running,
    input logic [NUM_VP-1:0] pending,
    input logic [NUM_VP-1:0] reset_req,
    input logic [NUM_VP-1:0] halt_req,
    input logic [NUM_VP-1:0] reset_done
);

    // R2
    run_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req & $past(running)) == '0);

    // R3
    no_double_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req & $past(pending)) == '0);

    // R4
    running_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running & ~$past(running) & ~$past(pending & reset_done)) == '0);

    // R5
    halt_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((halt_req & ~$past(running)) == '0) && ((halt_req & running) == '0));

    // R10
    reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req != '0) |=> ((reset_req & $past(reset_req)) == '0));

    // R10
    halt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req != '0) |=> ((halt_req & $past(halt_req)) == '0));

endmodule

bind vp_run_ctrl vp_run_ctrl_chk #(.NUM_VP(NUM_VP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .running   (running_vec),
    .pending   (pending_vec),
    .reset_req (vp_reset_req),
    .halt_req  (vp_halt_req),
    .reset_done(vp_reset_done)
);

// File: tb/tb_vp_run_ctrl.sv
module tb_vp_run_ctrl;

    localparam int NV = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [63:0]   bus_wdata = '0;
    logic [63:0]   bus_rdata;
    logic [NV-1:0] vp_reset_req;
    logic [NV-1:0] vp_halt_req;
    logic [NV-1:0] vp_reset_done = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    vp_run_ctrl #(
        .NUM_VP       (NV),
        .START_RUNNING(64'h5),
        .ADDR_W       (12)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .vp_reset_req (vp_reset_req),
        .vp_halt_req  (vp_halt_req),
        .vp_reset_done(vp_reset_done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ack(input logic [NV-1:0] m);
        @(negedge clk);
        vp_reset_done = m;
        @(negedge clk);
        vp_reset_done = '0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rd(12'h010, v);
        chk("R8 status during reset", v, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        rd(12'h010, v);
        chk("R8 status after release", v, 64'h0);
        chk("R8 no request before first edge", 64'(vp_reset_req), 64'h0);
        @(negedge clk);
        chk("R8 boot reset request", 64'(vp_reset_req), 64'h5);
        @(negedge clk);
        chk("R10 boot pulse ends", 64'(vp_reset_req), 64'h0);
        rd(12'h010, v);
        chk("R4 not running before ack", v, 64'h0);
        ack(4'b0101);
        rd(12'h010, v);
        chk("R4 running after ack", v, 64'h5);
    endtask

    task automatic t_run();
        logic [63:0] v;
        wr(12'h000, 64'hF);
        chk("R2 reset only idle VPs", 64'(vp_reset_req), 64'hA);
        chk("R2 no halt on run", 64'(vp_halt_req), 64'h0);
        wr(12'h000, 64'hF);
        chk("R3 no second reset while pending", 64'(vp_reset_req), 64'h0);
        rd(12'h010, v);
        chk("R4 pending not yet running", v, 64'h5);
        ack(4'b1000);
        rd(12'h010, v);
        chk("R4 VP3 running after ack", v, 64'hD);
        ack(4'b0100);
        rd(12'h010, v);
        chk("R4 ack without pending ignored", v, 64'hD);
        ack(4'b0010);
        rd(12'h010, v);
        chk("R4 all running", v, 64'hF);
    endtask

    task automatic t_stop();
        logic [63:0] v;
        wr(12'h108, 64'h3);
        chk("R5 halt selected running VPs", 64'(vp_halt_req), 64'h3);
        rd(12'h010, v);
        chk("R5 running cleared", v, 64'hC);
        wr(12'h108, 64'h3);
        chk("R5 no halt for stopped VPs", 64'(vp_halt_req), 64'h0);
        @(negedge clk);
        chk("R10 halt stays low", 64'(vp_halt_req), 64'h0);
    endtask

    task automatic t_mask();
        logic [63:0] v;
        wr(12'h008, 64'hFFFF_FFFF_FFFF_FFF0);
        chk("R1 high stop bits ignored", 64'(vp_halt_req), 64'h0);
        wr(12'h000, 64'hFFFF_FFFF_FFFF_FFF0);
        chk("R1 high run bits ignored", 64'(vp_reset_req), 64'h0);
        rd(12'h010, v);
        chk("R1 status unchanged", v, 64'hC);
    endtask

    task automatic t_alias();
        logic [63:0] v;
        rd(12'h110, v);
        chk("R7 status via window B", v, 64'hC);
        wr(12'h100, 64'h1);
        chk("R7 run via window B", 64'(vp_reset_req), 64'h1);
        ack(4'b0001);
        rd(12'h010, v);
        chk("R6 status window A", v, 64'hD);
        rd(12'h110, v);
        chk("R6 status window B", v, 64'hD);
    endtask

    task automatic t_other();
        logic [63:0] v;
        wr(12'h018, 64'hF);
        chk("R9 unmapped write no reset", 64'(vp_reset_req), 64'h0);
        chk("R9 unmapped write no halt", 64'(vp_halt_req), 64'h0);
        wr(12'h208, 64'hF);
        chk("R9 out-of-window write no halt", 64'(vp_halt_req), 64'h0);
        rd(12'h010, v);
        chk("R9 status unchanged", v, 64'hD);
        rd(12'h018, v);
        chk("R9 unmapped read zero", v, 64'h0);
        rd(12'h000, v);
        chk("R9 run offset reads zero", v, 64'h0);
        rd(12'h210, v);
        chk("R9 out-of-window read zero", v, 64'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_run();
        t_stop();
        t_mask();
        t_alias();
        t_other();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule